// File: doc/BRIEF.md
# Fixed-Priority Nesting Interrupt Controller

This block gathers fourteen interrupt sources and presents one request at a time to a processor. Seven sources are external pins. Pin 0 is a power monitor, and pins 1 to 6 are general inputs. The other seven are internal strobes: three from serial-port completions and four from timers. The external pins are synchronized and edge-detected. Every accepted event sets a pending flag. The controller then offers the most urgent enabled request, as a request line and a four-bit vector index.

The processor takes a request by pulsing an acknowledge, and ends a service routine by pulsing a return. Sources in service are held as a mask, ordered by priority. A new request interrupts the running routine only when it is strictly more urgent. The number of nested grants is capped by a parameter. Enable flags and pin polarities are set through a small register port. That port also reads back the pending flags and a power-fail flag.

Top module: `intc_top`

## Requirements
- R1: After reset, irqReq and nestDepth are 0. The enable mask, polarity, power-fail flag and pending flags all read as 0.
- R2: For pins 1 to 6, the pin's polarity bit is bit (pin-1) of register 1. A value of 1 latches rising edges and a value of 0 latches falling edges. An edge of the opposite direction leaves the pending flag clear.
- R3: Pin 0 (the power monitor) latches only falling edges. A rising edge on it never sets pending bit 0.
- R4: Every falling edge on pin 0 sets pwrFail, even when source 0 is disabled. Writing 1 to bit 0 of register 2 clears pwrFail.
- R5: Source k is enabled by bit k of register 0. An event from a disabled source sets no pending flag, which is read as bit k of register 3. A disabled source raises no request.
- R6: Source indices give the fixed priority, and index 0 is the most urgent: 0 is the monitor pin, 1 to 6 are the general pins, 7 to 9 are serial ports 0 to 2, and 10 to 13 are timers 0 to 3. irqVector names the lowest-index source that is pending and enabled.
- R7: An irqAck pulse while irqReq is high puts that source in service and clears its pending flag. It also raises nestDepth by one.
- R8: While sources are in service, irqReq is raised only for a source whose index is strictly lower than the most urgent source in service. Requests of equal or lower urgency stay pending.
- R9: An irqReturn pulse removes the most urgent source from service and lowers nestDepth by one. A return issued at depth 0 has no effect.
- R10: When nestDepth equals NEST_LIMIT (16 by default), irqReq stays low until a return frees a level.
- R11: An irqAck pulse while irqReq is low changes neither nestDepth nor the pending flags. When irqAck and irqReturn arrive in the same cycle, the return is processed and the acknowledge is ignored.
- R12: A one-cycle high pulse on intPulse[n] is latched as source 7+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPin | input | 7 | Asynchronous pins; bit 0 is the power monitor |
| intPulse | input | 7 | Internal event strobes: serial 0-2, then timers 0-3 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 enable, 1 polarity, 2 power flag, 3 pending |
| regWrData | input | 14 | Register write data |
| regRdData | output | 14 | Read data for regAddr (combinational) |
| irqReq | output | 1 | Request to the processor |
| irqVector | output | 4 | Index of the source being offered |
| irqAck | input | 1 | Acknowledge of the offered source |
| irqReturn | input | 1 | End of the current service routine |
| nestDepth | output | $clog2(NEST_LIMIT+1) | Number of sources in service |
| pwrFail | output | 1 | Power-off detected on pin 0 |

## Verification
A corrupted in-service mask shows up at the ports in one of two ways. A request can be wrongly held back or wrongly offered right after an acknowledge. Or, after a return, the wrong source can be offered again in the next cycle. Both are caught by sweeping every ordered pair of sources through a preempt scenario and a wait scenario.

A wrong pending or enable bit shows up on the pending register three clock edges after a pin changes, or one edge after an internal pulse. A depth count that drifts from the mask either blocks the next grant at the nesting cap or lets one too many through.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_PINS     = 7;
  localparam int NUM_INTERNAL = 7;
  localparam int NUM_SRC      = NUM_PINS + NUM_INTERNAL;
  localparam int IDX_W        = $clog2(NUM_SRC);
  localparam int REG_W        = NUM_SRC;
  localparam int ADDR_W       = 2;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_POLAR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_POWER  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PEND   = 2'd3;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             push;
    logic [IDX_W-1:0] pushIdx;
    logic             pop;
    logic [IDX_W-1:0] popIdx;
  } ctrl_strobe_t;
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync
  import intc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-2:0]   polarity,
  output logic [NUM_PINS-1:0]   pinEvent
);
  logic [NUM_PINS-1:0] syncA, syncB, lastB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      lastB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    if (g == 0) begin : gMonitor
      assign pinEvent[g] = ~syncB[g] & lastB[g];
    end else begin : gGeneral
      assign pinEvent[g] = polarity[g-1] ? (syncB[g] & ~lastB[g])
                                         : (~syncB[g] & lastB[g]);
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NEST_LIMIT = 16,
  parameter int DEPTH_W    = $clog2(NEST_LIMIT + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PINS-1:0]     pinEvent,
  input  logic [NUM_INTERNAL-1:0] intPulse,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [REG_W-1:0]        regWrData,
  input  ctrl_strobe_t            ctrl,
  output logic [REG_W-1:0]        regRdData,
  output logic [NUM_SRC-1:0]      enableMask,
  output logic [NUM_SRC-1:0]      pendingVec,
  output logic [NUM_SRC-1:0]      isrVec,
  output logic [NUM_PINS-2:0]     polarity,
  output logic [DEPTH_W-1:0]      depth,
  output logic                    pwrFail
);
  localparam logic [DEPTH_W-1:0] LIMIT_V = DEPTH_W'(NEST_LIMIT);

  logic [NUM_SRC-1:0] srcEvent, pendingNext, isrNext, pushMask, popMask;

  assign srcEvent = {intPulse, pinEvent};
  assign pushMask = ctrl.push ? (NUM_SRC'(1) << ctrl.pushIdx) : '0;
  assign popMask  = ctrl.pop  ? (NUM_SRC'(1) << ctrl.popIdx)  : '0;

  always_comb begin
    pendingNext = (pendingVec & ~pushMask) | (srcEvent & enableMask);
    isrNext     = (isrVec & ~popMask) | pushMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableMask <= '0;
      polarity   <= '0;
      pendingVec <= '0;
      isrVec     <= '0;
      depth      <= '0;
      pwrFail    <= 1'b0;
    end else begin
      pendingVec <= pendingNext;
      isrVec     <= isrNext;
      if (ctrl.push)     depth <= depth + 1'b1;
      else if (ctrl.pop) depth <= depth - 1'b1;
      if (regWrEn && regAddr == ADDR_ENABLE) enableMask <= regWrData[NUM_SRC-1:0];
      if (regWrEn && regAddr == ADDR_POLAR)  polarity   <= regWrData[NUM_PINS-2:0];
      if (pinEvent[0])
        pwrFail <= 1'b1;
      else if (regWrEn && regAddr == ADDR_POWER && regWrData[0])
        pwrFail <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_ENABLE: regRdData = REG_W'(enableMask);
      ADDR_POLAR:  regRdData = REG_W'(polarity);
      ADDR_POWER:  regRdData = REG_W'(pwrFail);
      default:     regRdData = REG_W'(pendingVec);
    endcase
  end

  // R7
  depth_matches_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    DEPTH_W'($countones(isrVec)) == depth);
  // R10
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= LIMIT_V);
  // R4
  power_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinEvent[0] |=> pwrFail);
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NEST_LIMIT = 16,
  parameter int DEPTH_W    = $clog2(NEST_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendingVec,
  input  logic [NUM_SRC-1:0] enableMask,
  input  logic [NUM_SRC-1:0] isrVec,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               irqAck,
  input  logic               irqReturn,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqVector,
  output ctrl_strobe_t       ctrl
);
  localparam logic [DEPTH_W-1:0] LIMIT_V = DEPTH_W'(NEST_LIMIT);

  logic [NUM_SRC-1:0] reqVec;
  logic [IDX_W-1:0]   bestIdx, topIdx;
  logic               anyReq, anyIsr;

  assign reqVec = pendingVec & enableMask;
  assign anyReq = |reqVec;
  assign anyIsr = |isrVec;

  always_comb begin
    bestIdx = '0;
    topIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) bestIdx = IDX_W'(i);
      if (isrVec[i]) topIdx  = IDX_W'(i);
    end
  end

  assign irqReq    = anyReq && (depth < LIMIT_V) && (!anyIsr || bestIdx < topIdx);
  assign irqVector = bestIdx;

  always_comb begin
    ctrl.pop     = irqReturn && anyIsr;
    ctrl.popIdx  = topIdx;
    ctrl.push    = irqAck && irqReq && !irqReturn;
    ctrl.pushIdx = bestIdx;
  end

  // R6
  vector_is_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> reqVec[irqVector]);
  // R8
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && anyIsr) |-> (irqVector < topIdx));
  // R9
  empty_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !irqAck && depth == '0) |=> depth == '0);
  // R7
  ack_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && !irqReturn) |=> depth == $past(depth) + 1'b1);
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NEST_LIMIT = 16,
  parameter int DEPTH_W    = $clog2(NEST_LIMIT + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PINS-1:0]     extPin,
  input  logic [NUM_INTERNAL-1:0] intPulse,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [REG_W-1:0]        regWrData,
  output logic [REG_W-1:0]        regRdData,
  output logic                    irqReq,
  output logic [IDX_W-1:0]        irqVector,
  input  logic                    irqAck,
  input  logic                    irqReturn,
  output logic [DEPTH_W-1:0]      nestDepth,
  output logic                    pwrFail
);
  logic [NUM_PINS-1:0] pinEvent;
  logic [NUM_PINS-2:0] polarity;
  logic [NUM_SRC-1:0]  enableMask, pendingVec, isrVec;
  ctrl_strobe_t        ctrl;

  intc_edge_sync u_sync (
    .clk(clk), .rstN(rstN), .pinIn(extPin), .polarity(polarity), .pinEvent(pinEvent)
  );

  intc_datapath #(.NEST_LIMIT(NEST_LIMIT), .DEPTH_W(DEPTH_W)) u_dp (
    .clk(clk), .rstN(rstN), .pinEvent(pinEvent), .intPulse(intPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .ctrl(ctrl),
    .regRdData(regRdData), .enableMask(enableMask), .pendingVec(pendingVec),
    .isrVec(isrVec), .polarity(polarity), .depth(nestDepth), .pwrFail(pwrFail)
  );

  intc_control #(.NEST_LIMIT(NEST_LIMIT), .DEPTH_W(DEPTH_W)) u_ctl (
    .clk(clk), .rstN(rstN), .pendingVec(pendingVec), .enableMask(enableMask),
    .isrVec(isrVec), .depth(nestDepth), .irqAck(irqAck), .irqReturn(irqReturn),
    .irqReq(irqReq), .irqVector(irqVector), .ctrl(ctrl)
  );
endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 3;
  localparam int DW         = $clog2(LIMIT + 1);

  logic        clk = 1'b0, rstN = 1'b0;
  logic [6:0]  extPin = '0, intPulse = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd3;
  logic [13:0] regWrData = '0;
  logic [13:0] regRdData;
  logic        irqReq, irqAck = 1'b0, irqReturn = 1'b0, pwrFail;
  logic [3:0]  irqVector;
  logic [DW-1:0] nestDepth;

  int nTests = 0, nFail = 0;

  intc_top #(.NEST_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .intPulse(intPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq), .irqVector(irqVector),
    .irqAck(irqAck), .irqReturn(irqReturn), .nestDepth(nestDepth), .pwrFail(pwrFail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(a); regWrData = 14'(d);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd3;
  endtask

  task automatic rdReg(input int a, output int d);
    regAddr = 2'(a);
    #1 d = int'(regRdData);
  endtask

  // Fires source k; general pins assume rising polarity
  task automatic fire(input int k);
    @(negedge clk);
    if (k >= 7) begin
      intPulse[k-7] = 1'b1;
      @(negedge clk);
      intPulse = '0;
      cyc(1);
    end else begin
      extPin[k] = 1'b1;
      cyc(5);
      extPin[k] = 1'b0;
      cyc(5);
    end
  endtask

  task automatic ack();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); irqReturn = 1'b1;
    @(negedge clk); irqReturn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int v;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    checkEq("R1 irqReq", int'(irqReq), 0);
    checkEq("R1 depth", int'(nestDepth), 0);
    checkEq("R1 pwrFail", int'(pwrFail), 0);
    for (int a = 0; a < 4; a++) begin
      rdReg(a, v);
      checkEq("R1 register", v, 0);
    end

    wrReg(1, 'h3F);
    // R5: disabled sources latch nothing; R4 flag still set
    for (int k = 0; k < 14; k++) fire(k);
    rdReg(3, v);
    checkEq("R5 pending while disabled", v, 0);
    checkEq("R5 irqReq while disabled", int'(irqReq), 0);
    checkEq("R4 flag set while disabled", int'(pwrFail), 1);
    wrReg(2, 1);
    checkEq("R4 flag cleared", int'(pwrFail), 0);

    // R6 R7 R9 R12 single-source sweep
    for (int k = 0; k < 14; k++) begin
      wrReg(0, 1 << k);
      fire(k);
      checkEq("R6 single irqReq", int'(irqReq), 1);
      checkEq("R6 R12 single vector", int'(irqVector), k);
      ack();
      checkEq("R7 depth after ack", int'(nestDepth), 1);
      rdReg(3, v);
      checkEq("R7 pending cleared", v, 0);
      checkEq("R7 no request after ack", int'(irqReq), 0);
      ret();
      checkEq("R9 depth after return", int'(nestDepth), 0);
      if (k == 0) begin
        checkEq("R4 monitor flag", int'(pwrFail), 1);
        wrReg(2, 1);
      end
    end

    // R2 falling polarity on general pins
    wrReg(1, 0);
    wrReg(0, 'h7E);
    for (int k = 1; k < 7; k++) begin
      @(negedge clk); extPin[k] = 1'b1; cyc(5);
      rdReg(3, v);
      checkEq("R2 rising ignored when falling selected", v, 0);
      extPin[k] = 1'b0; cyc(5);
      rdReg(3, v);
      checkEq("R2 falling latched", v, 1 << k);
      ack(); ret();
    end
    wrReg(1, 'h3F);

    // R3 monitor rising never latched
    wrReg(0, 1);
    @(negedge clk); extPin[0] = 1'b1; cyc(5);
    rdReg(3, v);
    checkEq("R3 monitor rising ignored", v, 0);
    extPin[0] = 1'b0; cyc(5);
    rdReg(3, v);
    checkEq("R3 monitor falling latched", v, 1);
    ack(); ret(); wrReg(2, 1);

    // R6 R8 pairwise sweep
    wrReg(0, 'h3FFF);
    for (int i = 0; i < 14; i++) begin
      for (int j = i + 1; j < 14; j++) begin
        fire(j); fire(i);
        checkEq("R6 pair vector", int'(irqVector), i);
        ack();
        checkEq("R8 lower waits", int'(irqReq), 0);
        ret();
        checkEq("R8 lower offered after return", int'(irqVector), j);
        ack(); ret();
        fire(j); ack(); fire(i);
        checkEq("R8 higher preempts req", int'(irqReq), 1);
        checkEq("R8 higher preempts vector", int'(irqVector), i);
        ack();
        checkEq("R8 nested depth", int'(nestDepth), 2);
        ret();
        checkEq("R9 return pops higher", int'(irqReq), 0);
        ret();
        checkEq("R9 depth empty", int'(nestDepth), 0);
      end
    end
    wrReg(2, 1);

    // R8 equal priority does not preempt
    fire(13); ack(); fire(13);
    checkEq("R8 equal no preempt", int'(irqReq), 0);
    ret();
    checkEq("R8 equal offered after return", int'(irqVector), 13);
    ack(); ret();

    // R10 nesting cap
    fire(13); ack(); fire(12); ack(); fire(11); ack();
    checkEq("R10 depth at cap", int'(nestDepth), LIMIT);
    fire(10);
    checkEq("R10 blocked at cap", int'(irqReq), 0);
    rdReg(3, v);
    checkEq("R10 still pending", v, 1 << 10);
    ret();
    checkEq("R10 offered after return", int'(irqVector), 10);
    ack(); ret(); ret(); ret();
    checkEq("R10 unwound", int'(nestDepth), 0);

    // R9 empty return, R11 stray ack
    ret();
    checkEq("R9 empty return", int'(nestDepth), 0);
    ack();
    checkEq("R11 stray ack", int'(nestDepth), 0);
    // R11 ack with return same cycle: return wins
    fire(9);
    @(negedge clk); irqAck = 1'b1; irqReturn = 1'b1;
    @(negedge clk); irqAck = 1'b0; irqReturn = 1'b0;
    checkEq("R11 simultaneous ack ignored", int'(nestDepth), 0);
    rdReg(3, v);
    checkEq("R11 pending kept", v, 1 << 9);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule